// File: doc/BRIEF.md
# Noise-Tolerant Second Interval Estimator

This block estimates how many local ticks make up one true second, using a once-per-second pulse from a radio time receiver. The pulse is active-high, and the rising edge marks the start of each second. A tick counter counts enabled ticks between consecutive rising edges. Each measured interval is then either accepted or rejected. An interval is accepted only when it falls inside a narrow window around the nominal tick count. Edges that come too early, such as receiver burst noise, are rejected. Edges that come too late, such as after a missed pulse, are also rejected.

Accepted intervals go into a circular history of fixed depth, with a running sum beside it. Each new sample adds its value to the sum and, once the history is full, removes the oldest sample. The published estimate is the integer mean of the history. Because it is a mean and not a clamp, the estimate follows an oscillator that runs off its nominal frequency. Until the history is full, the block outputs the nominal count and holds its valid flag low. A downstream reference-second generator uses the estimate as its period.

Top module: `sec_interval_est`

## Requirements
- R1: While reset is active and after it is released, `avgInterval` equals NOMINAL, and `avgValid`, `edgeAccept` and `edgeReject` are 0.
- R2: A rising edge is a clock cycle in which `pulseIn` is 1 after a cycle in which it was 0. The interval measured at an edge is the number of cycles with `tickEn`=1, counted from the cycle after the previous edge up to and including the edge's own cycle.
- R3: An edge whose interval lies in [NOMINAL-NOMINAL/TOL_DIV, NOMINAL+NOMINAL/TOL_DIV], bounds included, is accepted. `edgeAccept` is 1 for exactly the cycle after the edge.
- R4: An edge whose interval is below the window minimum is rejected: `edgeReject` is 1 for the cycle after it, and no sample is stored. Measurement of the next interval starts from this edge.
- R5: An edge whose interval is above the window maximum is rejected and stores no sample; the average is held. Measurement restarts from this edge.
- R6: The first edge after reset is rejected, because it has no previous edge to measure from, and starts measurement.
- R7: Until DEPTH samples have been accepted, `avgInterval` stays at NOMINAL and `avgValid` stays 0.
- R8: From the DEPTH-th accepted sample on, `avgValid` is 1 and stays 1. `avgInterval` equals floor(sum of the last DEPTH accepted intervals / DEPTH), updated in the same cycle that `edgeAccept` rises.
- R9: A sustained off-nominal interval inside the window becomes the average exactly; it is not pulled toward NOMINAL.
- R10: `edgeAccept` and `edgeReject` are never 1 together, and each stays high for a single cycle.
- R11: `avgInterval` and `avgValid` change only in the cycle that follows an accepted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Synchronized second pulse, active-high |
| tickEn | input | 1 | Tick enable; one tick per cycle while high |
| avgInterval | output | CNT_W = clog2(NOMINAL+NOMINAL/TOL_DIV+3) | Averaged ticks per second |
| avgValid | output | 1 | History full; average is meaningful |
| edgeAccept | output | 1 | One-cycle strobe: last edge produced a sample |
| edgeReject | output | 1 | One-cycle strobe: last edge was discarded |

## Verification
Every result of an edge is due one clock after the edge cycle: the accept or reject strobe, the new average and the valid flag. The bench raises the pulse at a falling clock edge, lets one rising edge pass, and then samples all four outputs at the next falling edge. At the falling edge after that, it checks that both strobes have dropped and that the average has held. The bench counts the ticks it drives itself, so the expected interval, the window decision and the mean of the last DEPTH accepted values all come from its own model.

// File: rtl/sie_pkg.sv
package sie_pkg;
  typedef struct packed {
    logic edgeSeen;
    logic pushSample;
  } ctrlStrb_t;
endpackage

// File: rtl/sie_ctrl.sv
module sie_ctrl
  import sie_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int WIN_MIN = 45938,
  parameter int WIN_MAX = 47812
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseIn,
  input  logic             tickEn,
  output logic [CNT_W-1:0] sample,
  output ctrlStrb_t        strb,
  output logic             edgeAccept,
  output logic             edgeReject
);
  localparam int SAT_LIM = WIN_MAX + 1;

  logic             pulsePrev;
  logic             anchored;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] measured;
  logic             rise;
  logic             inWin;

  assign rise     = pulseIn & ~pulsePrev;
  assign measured = tickCnt + CNT_W'(tickEn);
  assign inWin    = (measured >= CNT_W'(WIN_MIN)) && (measured <= CNT_W'(WIN_MAX));
  assign sample   = measured;

  always_comb begin
    strb.edgeSeen   = rise;
    strb.pushSample = rise & anchored & inWin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulsePrev  <= 1'b0;
      anchored   <= 1'b0;
      tickCnt    <= '0;
      edgeAccept <= 1'b0;
      edgeReject <= 1'b0;
    end else begin
      pulsePrev  <= pulseIn;
      edgeAccept <= strb.pushSample;
      edgeReject <= rise & ~strb.pushSample;
      if (rise) begin
        tickCnt  <= '0;
        anchored <= 1'b1;
      end else if (tickEn && (tickCnt < CNT_W'(SAT_LIM))) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(edgeAccept && edgeReject));

  // R10
  accept_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeAccept |=> !edgeAccept);

  // R10
  reject_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeReject |=> !edgeReject);

  // R6
  first_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rise && !anchored) |=> (edgeReject && !edgeAccept));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> (tickCnt == '0));
endmodule

// File: rtl/sie_avg_dp.sv
module sie_avg_dp
  import sie_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DEPTH   = 300,
  parameter int NOMINAL = 46875,
  parameter int WIN_MIN = 45938,
  parameter int WIN_MAX = 47812
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [CNT_W-1:0] sample,
  output logic [CNT_W-1:0] avgInterval,
  output logic             avgValid
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam int SUM_W  = CNT_W + PTR_W + 1;

  logic [CNT_W-1:0]  ring [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [FILL_W-1:0] fillCnt;
  logic [SUM_W-1:0]  runSum;
  logic [SUM_W-1:0]  nextSum;
  logic [CNT_W-1:0]  oldest;
  logic              full;
  logic              becomingFull;

  assign full         = (fillCnt == FILL_W'(DEPTH));
  assign becomingFull = (fillCnt == FILL_W'(DEPTH - 1));
  assign oldest       = full ? ring[wrPtr] : '0;
  assign nextSum      = runSum + SUM_W'(sample) - SUM_W'(oldest);

  always_ff @(posedge clk) begin
    if (strb.pushSample) ring[wrPtr] <= sample;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      fillCnt     <= '0;
      runSum      <= '0;
      avgInterval <= CNT_W'(NOMINAL);
      avgValid    <= 1'b0;
    end else if (strb.pushSample) begin
      runSum <= nextSum;
      wrPtr  <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (!full) fillCnt <= fillCnt + 1'b1;
      if (full || becomingFull) begin
        avgInterval <= CNT_W'(nextSum / SUM_W'(DEPTH));
        avgValid    <= 1'b1;
      end
    end
  end

  // R3
  win_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushSample |-> (sample >= CNT_W'(WIN_MIN) && sample <= CNT_W'(WIN_MAX)));

  // R3
  push_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushSample |-> strb.edgeSeen);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pushSample |=> ($stable(avgInterval) && $stable(avgValid)));

  // R8
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    avgValid |=> avgValid);

  // R7
  nominal_until_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !avgValid |-> (avgInterval == CNT_W'(NOMINAL)));

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= FILL_W'(DEPTH));
endmodule

// File: rtl/sec_interval_est.sv
module sec_interval_est
  import sie_pkg::*;
#(
  parameter int NOMINAL = 46875,
  parameter int DEPTH   = 300,
  parameter int TOL_DIV = 50,
  localparam int TOL     = NOMINAL / TOL_DIV,
  localparam int WIN_MIN = NOMINAL - TOL,
  localparam int WIN_MAX = NOMINAL + TOL,
  localparam int CNT_W   = $clog2(WIN_MAX + 3)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseIn,
  input  logic             tickEn,
  output logic [CNT_W-1:0] avgInterval,
  output logic             avgValid,
  output logic             edgeAccept,
  output logic             edgeReject
);
  ctrlStrb_t        strb;
  logic [CNT_W-1:0] sample;

  sie_ctrl #(.CNT_W(CNT_W), .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .tickEn(tickEn),
    .sample(sample), .strb(strb),
    .edgeAccept(edgeAccept), .edgeReject(edgeReject)
  );

  sie_avg_dp #(.CNT_W(CNT_W), .DEPTH(DEPTH), .NOMINAL(NOMINAL),
               .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sample(sample),
    .avgInterval(avgInterval), .avgValid(avgValid)
  );
endmodule

// File: tb/sec_interval_est_bench.sv
module sec_interval_est_bench;
  localparam int NOM  = 200;
  localparam int DEP  = 8;
  localparam int TOLV = NOM / 50;
  localparam int WMIN = NOM - TOLV;
  localparam int WMAX = NOM + TOLV;
  localparam int CW   = $clog2(WMAX + 3);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseIn = 1'b0;
  logic tickEn = 1'b0;
  logic [CW-1:0] avgInterval;
  logic avgValid, edgeAccept, edgeReject;

  sec_interval_est #(.NOMINAL(NOM), .DEPTH(DEP), .TOL_DIV(50)) u_sec_interval_est (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .tickEn(tickEn),
    .avgInterval(avgInterval), .avgValid(avgValid),
    .edgeAccept(edgeAccept), .edgeReject(edgeReject)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit anchored = 1'b0;
  int ring [DEP];
  int wp = 0;
  int fill = 0;
  int sum = 0;

  function automatic int expAvg();
    return (fill == DEP) ? sum / DEP : NOM;
  endfunction

  function automatic bit inWindow(int n);
    return (n >= WMIN) && (n <= WMAX);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic sendEdge(int n, string tag);
    int t = 0;
    bit acc;
    int prevAvg;
    while (t < n) begin
      bit tk;
      @(negedge clk);
      tk = ($urandom % 4) != 0;
      tickEn = tk;
      if (tk) t++;
      if (t == n) pulseIn = 1'b1;
    end
    @(negedge clk);
    pulseIn = 1'b0;
    tickEn = 1'b0;
    acc = anchored && inWindow(n);
    anchored = 1'b1;
    if (acc) begin
      if (fill == DEP) sum -= ring[wp];
      else fill++;
      ring[wp] = n;
      sum += n;
      wp = (wp + 1) % DEP;
    end
    check(tag, "edgeAccept", int'(edgeAccept), int'(acc));
    check(tag, "edgeReject", int'(edgeReject), int'(!acc));
    check(tag, "avgInterval", int'(avgInterval), expAvg());
    check(tag, "avgValid", int'(avgValid), int'(fill == DEP));
    prevAvg = int'(avgInterval);
    @(negedge clk);
    // R10 strobes single cycle, R11 average held without an accept
    check("R10", "strobes low", int'(edgeAccept | edgeReject), 0);
    check("R11", "avg held", int'(avgInterval), prevAvg);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "avgInterval in reset", int'(avgInterval), NOM);
    check("R1", "avgValid in reset", int'(avgValid), 0);
    check("R1", "strobes in reset", int'(edgeAccept | edgeReject), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "avgInterval after reset", int'(avgInterval), NOM);

    sendEdge(NOM, "R6");
    for (int i = 0; i < DEP - 1; i++) sendEdge(WMIN + int'($urandom % (2 * TOLV + 1)), "R7");
    sendEdge(NOM + 1, "R8");

    sendEdge(WMIN - 1, "R4");
    sendEdge(WMIN, "R3");
    sendEdge(WMAX, "R3");
    sendEdge(WMAX + 1, "R5");
    sendEdge(3 * NOM, "R5");
    sendEdge(15, "R4");
    sendEdge(NOM - 15, "R4");
    sendEdge(NOM, "R2");

    for (int i = 0; i < DEP; i++) sendEdge(WMAX, "R9");
    check("R9", "off-nominal average", int'(avgInterval), WMAX);

    for (int i = 0; i < 120; i++) begin
      int r = int'($urandom % 10);
      if (r < 6) sendEdge(WMIN + int'($urandom % (2 * TOLV + 1)), "R8");
      else if (r < 8) sendEdge(1 + int'($urandom % (WMIN - 1)), "R4");
      else if (r < 9) sendEdge(WMAX + 1 + int'($urandom % NOM), "R5");
      else sendEdge(((($urandom % 2) == 0) ? WMIN - 1 : WMAX + 1), "R3");
    end
    finishRun();
  end
endmodule